// File: doc/BRIEF.md
# Cascadable Up/Down Counter with Synchronous Load

A synchronous binary counter whose every bit is a D flip-flop. On each rising clock edge the register is cleared, loaded with a parallel word, stepped up by one, stepped down by one, or left as it is. When counting, each bit's next value is its toggle condition XORed with its present value. A bit toggles upward when every lower bit is one, and downward when every lower bit is zero. Otherwise the D path simply recirculates the stored value, so hold costs no extra logic.

Two combinational outputs report a terminal count, one for each direction. When such a flag drives the count enable of the next, more significant counter, several counters form one wider counter. The default width is 4 bits.

Top module: `updn_load_counter`

## Requirements
- R1: `par_in[j]` is loaded into `q[j]` for every bit j, so `par_in[0]` is the least significant bit. The width is set by the parameter WIDTH, which defaults to 4.
- R2: When `clr_n` is low at a rising edge, `q` becomes all zeros after that edge. Clear takes priority over load and over counting.
- R3: When `clr_n` is high and `load` is high at a rising edge, `q` takes the value of `par_in` after that edge and not before. Load takes priority over counting.
- R4: With `clr_n` high and `load` low, `q` holds its value for any number of edges if `cnt_en` is low or if `up` equals `dn`.
- R5: When `clr_n` is high, `load` is low, `cnt_en` is high, `up` is high and `dn` is low, `q` increments by one at each edge. It wraps from all ones to zero.
- R6: When `clr_n` is high, `load` is low, `cnt_en` is high, `dn` is high and `up` is low, `q` decrements by one at each edge. It wraps from zero to all ones.
- R7: `carry_out` is high exactly when the R5 count-up condition holds and `q` is all ones.
- R8: `borrow_out` is high exactly when the R6 count-down condition holds and `q` is zero.
- R9: A second counter whose `cnt_en` is driven by the first counter's `carry_out | borrow_out` makes the pair count as one counter of twice the width, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| clr_n | input | 1 | Synchronous clear, active low |
| load | input | 1 | Synchronous parallel load |
| up | input | 1 | Count-up select |
| dn | input | 1 | Count-down select |
| cnt_en | input | 1 | Count enable, or cascade input from a lower counter |
| par_in | input | WIDTH | Parallel load word |
| q | output | WIDTH | Counter state |
| carry_out | output | 1 | Terminal count while counting up |
| borrow_out | output | 1 | Terminal count while counting down |

## Verification
Long runs of plain up-counting and down-counting cross both wrap points. Because the cascaded pair is checked at the same time, these runs separate a correct toggle chain from one that takes the wrong lower bits into account, and they show whether the terminal flags fire on exactly one state.

Directed cases set clear, load and a count mode at the same time to expose errors in the priority order. Holds are tried with `cnt_en` low and with both direction selects high, which separates true hold from a stray toggle. A long stretch of random control and data words then mixes loads in the middle of a count with changes of direction.

// File: rtl/updn_load_counter.sv
module updn_load_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load,
  input  logic             up,
  input  logic             dn,
  input  logic             cnt_en,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q,
  output logic             carry_out,
  output logic             borrow_out
);
  logic             step_ok, go_up, go_dn;
  logic [WIDTH:0]   low_ones, low_zeros;
  logic [WIDTH-1:0] tgl, d;

  assign step_ok = clr_n & ~load & cnt_en;
  assign go_up   = step_ok & up & ~dn;
  assign go_dn   = step_ok & dn & ~up;

  assign low_ones[0]  = 1'b1;
  assign low_zeros[0] = 1'b1;

  for (genvar j = 0; j < WIDTH; j++) begin : g_bit
    assign low_ones[j+1]  = low_ones[j] & q[j];
    assign low_zeros[j+1] = low_zeros[j] & ~q[j];
    assign tgl[j] = (go_up & low_ones[j]) | (go_dn & low_zeros[j]);
    assign d[j]   = !clr_n ? 1'b0 : (load ? par_in[j] : (tgl[j] ^ q[j]));
  end

  always_ff @(posedge clk) q <= d;

  assign carry_out  = go_up & low_ones[WIDTH];
  assign borrow_out = go_dn & low_zeros[WIDTH];
endmodule

module updn_load_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load,
  input logic             up,
  input logic             dn,
  input logic             cnt_en,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] q,
  input logic             carry_out,
  input logic             borrow_out
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) armed <= 1'b1;

  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> q == '0);
  a_r3_load_word: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load) |=> q == $past(par_in));
  a_r4_true_hold: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !load && (!cnt_en || up == dn)) |=> $stable(q));
  a_r5_step_up: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !load && cnt_en && up && !dn) |=> q == WIDTH'($past(q) + 1'b1));
  a_r6_step_down: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !load && cnt_en && dn && !up) |=> q == WIDTH'($past(q) - 1'b1));
  a_r7_carry_at_top: assert property (@(posedge clk) disable iff (!armed)
    carry_out |-> (q == '1 && up && !dn && cnt_en && clr_n && !load));
  a_r8_borrow_at_bottom: assert property (@(posedge clk) disable iff (!armed)
    borrow_out |-> (q == '0 && dn && !up && cnt_en && clr_n && !load));
endmodule

bind updn_load_counter updn_load_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .clr_n(clr_n), .load(load), .up(up), .dn(dn), .cnt_en(cnt_en),
  .par_in(par_in), .q(q), .carry_out(carry_out), .borrow_out(borrow_out)
);

// File: tb/updn_load_counter_tb.sv
module updn_load_counter_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       clr_n = 1'b1, load = 1'b0, up = 1'b0, dn = 1'b0, cnt_en = 1'b0;
  logic [3:0] par_lo = '0, par_hi = '0;
  logic [3:0] q_lo, q_hi;
  logic       co_lo, bo_lo, co_hi, bo_hi, en_hi;

  assign en_hi = co_lo | bo_lo;

  updn_load_counter #(.WIDTH(4)) u_dut (
    .clk(clk), .clr_n(clr_n), .load(load), .up(up), .dn(dn), .cnt_en(cnt_en),
    .par_in(par_lo), .q(q_lo), .carry_out(co_lo), .borrow_out(bo_lo));

  updn_load_counter #(.WIDTH(4)) u_hi (
    .clk(clk), .clr_n(clr_n), .load(load), .up(up), .dn(dn), .cnt_en(en_hi),
    .par_in(par_hi), .q(q_hi), .carry_out(co_hi), .borrow_out(bo_hi));

  int    checks = 0, fails = 0;
  int    m_lo = 0, m_hi = 0;
  bit    valid = 1'b0;
  string tag = "R2";

  function automatic bit m_go_up();
    return clr_n && !load && cnt_en && up && !dn;
  endfunction
  function automatic bit m_go_dn();
    return clr_n && !load && cnt_en && dn && !up;
  endfunction

  always @(posedge clk) begin
    bit e_hi;
    e_hi = (m_go_up() && m_lo == 15) || (m_go_dn() && m_lo == 0);
    if (!clr_n) begin
      m_lo = 0; m_hi = 0; valid = 1'b1; tag = "R2";
    end else if (load) begin
      m_lo = par_lo; m_hi = par_hi; tag = "R3 (R1 bit order)";
    end else if (m_go_up()) begin
      m_lo = (m_lo + 1) % 16; if (e_hi) m_hi = (m_hi + 1) % 16; tag = "R5";
    end else if (m_go_dn()) begin
      m_lo = (m_lo + 15) % 16; if (e_hi) m_hi = (m_hi + 15) % 16; tag = "R6";
    end else tag = "R4";
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit c_n, bit ld, bit u, bit d, bit en, logic [3:0] pl, logic [3:0] ph);
    @(negedge clk);
    if (valid) begin
      bit eco, ebo;
      eco = m_go_up() && m_lo == 15;
      ebo = m_go_dn() && m_lo == 0;
      chk(tag, int'(q_lo), m_lo);
      chk("R9", int'(q_hi), m_hi);
      chk("R7", int'(co_lo), int'(eco));
      chk("R8", int'(bo_lo), int'(ebo));
    end
    clr_n = c_n; load = ld; up = u; dn = d; cnt_en = en; par_lo = pl; par_hi = ph;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    step(0, 0, 0, 0, 0, 4'h0, 4'h0);
    step(0, 1, 1, 0, 1, 4'h9, 4'h3);
    step(1, 1, 0, 0, 0, 4'h1, 4'h8);
    step(1, 1, 0, 0, 0, 4'h8, 4'h1);
    for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 0, 4'h0, 4'h0);
    for (int i = 0; i < 4; i++) step(1, 0, 1, 1, 1, 4'h0, 4'h0);
    step(1, 1, 0, 0, 0, 4'hC, 4'hE);
    for (int i = 0; i < 60; i++) step(1, 0, 1, 0, 1, 4'h0, 4'h0);
    step(0, 0, 0, 0, 0, 4'h0, 4'h0);
    for (int i = 0; i < 60; i++) step(1, 0, 0, 1, 1, 4'h0, 4'h0);
    step(1, 1, 1, 0, 1, 4'h5, 4'h0);
    step(1, 0, 0, 1, 1, 4'h0, 4'h0);
    for (int i = 0; i < 400; i++) begin
      logic [7:0] r = 8'($urandom);
      step(r[7:2] != 0, r[6:3] == 0, r[0], r[1], r[5:4] != 0,
           4'($urandom), 4'($urandom));
    end
    step(1, 0, 0, 0, 0, 4'h0, 4'h0);
    step(1, 0, 0, 0, 0, 4'h0, 4'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule